// File: doc/BRIEF.md
# Filtered Input Change Interrupt Unit

This unit gathers event sources for a bank of eight-channel, 24 V style I/O into a single interrupt request. Each channel that is configured as an input is debounced by a counter. The counter advances only on strobes from a separate, slower filter timebase. When the debounced level of such a channel changes, a change cause is raised. The unit also takes a short-circuit flag for each output and two thermal levels (warning and critical). A rising edge on any of these raises its own cause.

Each cause is latched in a pending register and held until software writes a 1 to that bit. A clear never removes an event that arrives in the same cycle. An event that repeats while its cause is still pending is recorded in an overflow register, so no occurrence goes unnoticed. An enable register selects which pending causes drive the active-low interrupt output. A small register port gives access to the debounce length, the enables, the pending and overflow bits, and the live debounced levels and short flags.

Cause bit layout: bits 0 to NCH-1 are channel changes, bits NCH to 2·NCH-1 are output shorts, bit 2·NCH is thermal warning and bit 2·NCH+1 is thermal critical. With the default NCH=8 this gives 18 bits.

Top module: `fei_irq_unit`

## Requirements
- R1: The debounced level of a channel takes the raw level only after the raw level has differed from it on N consecutive cycles with `filt_tick` high. A tick on which they match restarts the count. Cycles without a tick neither advance nor restart it.
- R2: The debounce length N sits in bits [3:0] of address 3 and resets to 4. A write of 0 is stored and read back as 1, so N always stays between 1 and 15.
- R3: A debounced level change on channel i raises pending bit i (address 0) one clock after the level changes, but only when `chan_is_in[i]` is 1. A channel with `chan_is_in[i]`=0 still updates its level but raises no cause.
- R4: A rising edge of `short_flag[i]` raises pending bit NCH+i on the following clock edge. Address 4 reads the live short flags in bits [2·NCH-1:NCH] and the debounced levels in bits [NCH-1:0].
- R5: A rising edge of `temp_warn` raises pending bit 2·NCH, and a rising edge of `temp_crit` raises pending bit 2·NCH+1. The two are independent of each other.
- R6: Writing address 0 clears every pending bit written as 1 and leaves the bits written as 0 unchanged.
- R7: When a cause's event and the clear of its bit happen in the same cycle, the bit stays pending and no overflow is recorded.
- R8: An event whose cause is already pending and not being cleared sets the same bit of the overflow register (address 2). That register is cleared by writing 1s to it.
- R9: The enable register (address 1, one bit per cause, reset 0) gates the causes. `irq_n` goes low on the clock after an enabled cause is pending, and goes high one clock after the last enabled pending cause is cleared.
- R10: After reset, the pending, overflow and enable registers are zero, all debounced levels are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_tick | input | 1 | One-cycle strobe from the filter timebase |
| chan_in | input | NCH | Raw channel levels, synchronous to clk |
| chan_is_in | input | NCH | 1 = channel is configured as an input |
| short_flag | input | NCH | Per-output short-circuit indication |
| temp_warn | input | 1 | Thermal warning level |
| temp_crit | input | 1 | Thermal critical level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 2·NCH+2 | Write data |
| reg_rdata | output | 2·NCH+2 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest state to reach from the ports is an event that lands in the exact cycle its pending bit is being cleared. The bench first lowers the short flag for one clock. It then raises the flag on the same falling edge that presents the clear write, so both take effect on one rising edge. A debounce restart is forced by returning the raw level to the debounced value for a single tick midway through the count. Idle cycles without ticks are also inserted, and they must not complete the count.

// File: rtl/fei_pkg.sv
package fei_pkg;

    localparam int LEN_W    = 4;
    localparam int LEN_RST  = 4;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND = 3'd0,
        RA_EN   = 3'd1,
        RA_OVF  = 3'd2,
        RA_LEN  = 3'd3,
        RA_LIVE = 3'd4
    } reg_sel_e;

    // a length of zero would let a single tick pass anything: force at least one
    function automatic logic [LEN_W-1:0] len_floor(input logic [LEN_W-1:0] v);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

endpackage

// File: rtl/fei_debounce.sv
module fei_debounce
    import fei_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             raw,
    input  logic [LEN_W-1:0] len,
    output logic             lvl,
    output logic             chg
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            cnt <= '0;
            chg <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (tick) begin
                if (raw == lvl) begin
                    cnt <= '0;
                end else if (({1'b0, cnt} + 1'b1) >= {1'b0, len}) begin
                    lvl <= raw;
                    cnt <= '0;
                    chg <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: the level only moves on a filter tick
    a_r1_hold_off_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lvl));

    // R1: a change pulse always follows a tick
    a_r1_chg_after_tick: assert property (@(posedge clk) disable iff (rst)
        chg |-> $past(tick));

endmodule

// File: rtl/fei_cause_bank.sv
module fei_cause_bank #(
    parameter int NC = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] evt,
    input  logic [NC-1:0] pend_clr,
    input  logic [NC-1:0] ovf_clr,
    output logic [NC-1:0] pend,
    output logic [NC-1:0] ovf
);
    logic [NC-1:0] keep;
    assign keep = pend & ~pend_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ovf  <= '0;
        end else begin
            pend <= evt | keep;
            ovf  <= (evt & keep) | (ovf & ~ovf_clr);
        end
    end

    // R7: an arriving event is never lost, even against a clear
    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    // R6: a cleared bit with no new event drops
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        ((pend_clr & ~evt) != '0) |=> ((pend & $past(pend_clr & ~evt)) == '0));

    // R8: overflow bits only fall when written
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(ovf) & ~ovf) & ~$past(ovf_clr)) == '0));

endmodule

// File: rtl/fei_irq_drv.sv
module fei_irq_drv #(
    parameter int NC = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] pend,
    input  logic [NC-1:0] en,
    output logic          irq_n
);
    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= ~|(pend & en);
    end
endmodule

// File: rtl/fei_irq_unit.sv
module fei_irq_unit
    import fei_pkg::*;
#(
    parameter int NCH = 8,
    localparam int NC = 2 * NCH + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              filt_tick,
    input  logic [NCH-1:0]    chan_in,
    input  logic [NCH-1:0]    chan_is_in,
    input  logic [NCH-1:0]    short_flag,
    input  logic              temp_warn,
    input  logic              temp_crit,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NC-1:0]     reg_wdata,
    output logic [NC-1:0]     reg_rdata,
    output logic              irq_n
);
    localparam int WARN_BIT = 2 * NCH;
    localparam int CRIT_BIT = 2 * NCH + 1;

    reg_sel_e         sel;
    logic [LEN_W-1:0] flen;
    logic [NC-1:0]    en, pend, ovf, evt, pend_clr, ovf_clr;
    logic [NCH-1:0]   lvl, chg, short_q;
    logic             warn_q, crit_q;

    assign sel = reg_sel_e'(reg_addr);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        fei_debounce u_deb (
            .clk  (clk),
            .rst  (rst),
            .tick (filt_tick),
            .raw  (chan_in[i]),
            .len  (flen),
            .lvl  (lvl[i]),
            .chg  (chg[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flen    <= LEN_W'(LEN_RST);
            en      <= '0;
            short_q <= '0;
            warn_q  <= 1'b0;
            crit_q  <= 1'b0;
        end else begin
            short_q <= short_flag;
            warn_q  <= temp_warn;
            crit_q  <= temp_crit;
            if (reg_wr && sel == RA_LEN) flen <= len_floor(reg_wdata[LEN_W-1:0]);
            if (reg_wr && sel == RA_EN)  en   <= reg_wdata;
        end
    end

    always_comb begin
        evt                    = '0;
        evt[NCH-1:0]           = chg & chan_is_in;
        evt[2*NCH-1:NCH]       = short_flag & ~short_q;
        evt[WARN_BIT]          = temp_warn & ~warn_q;
        evt[CRIT_BIT]          = temp_crit & ~crit_q;
    end

    assign pend_clr = (reg_wr && sel == RA_PEND) ? reg_wdata : '0;
    assign ovf_clr  = (reg_wr && sel == RA_OVF)  ? reg_wdata : '0;

    fei_cause_bank #(.NC(NC)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .pend_clr (pend_clr),
        .ovf_clr  (ovf_clr),
        .pend     (pend),
        .ovf      (ovf)
    );

    fei_irq_drv #(.NC(NC)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .en    (en),
        .irq_n (irq_n)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            RA_PEND: reg_rdata = pend;
            RA_EN:   reg_rdata = en;
            RA_OVF:  reg_rdata = ovf;
            RA_LEN:  reg_rdata[LEN_W-1:0] = flen;
            RA_LIVE: reg_rdata[2*NCH-1:0] = {short_flag, lvl};
            default: reg_rdata = '0;
        endcase
    end

    // R2: the stored length is never zero
    a_r2_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        flen != '0);

    // R9: the request is only low if an enabled cause was pending
    a_r9_low_needs_cause: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> $past((pend & en) != '0));

    // R3: an output channel never raises a change cause
    a_r3_out_silent: assert property (@(posedge clk) disable iff (rst)
        ((evt[NCH-1:0] & ~chan_is_in) == '0));

endmodule

// File: tb/fei_irq_unit_bench.sv
`timescale 1ns/1ps
module fei_irq_unit_bench;
    localparam int NCH = 8;
    localparam int NC  = 2 * NCH + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic filt_tick = 1'b0;
    logic [NCH-1:0] chan_in = '0, chan_is_in = '1, short_flag = '0;
    logic temp_warn = 1'b0, temp_crit = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [NC-1:0] reg_wdata = '0;
    logic [NC-1:0] reg_rdata;
    logic irq_n;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fei_irq_unit #(.NCH(NCH)) u_fei_irq_unit (
        .clk(clk), .rst(rst), .filt_tick(filt_tick), .chan_in(chan_in),
        .chan_is_in(chan_is_in), .short_flag(short_flag), .temp_warn(temp_warn),
        .temp_crit(temp_crit), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic tick();
        filt_tick = 1'b1; step(); filt_tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [NC-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; step(); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NC-1:0] v);
        reg_addr = a; #0.5; v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [NC-1:0] v;
        chk("R10 irq_n", 32'(irq_n), 1);
        rd(0, v); chk("R10 pending", 32'(v), 0);
        rd(1, v); chk("R10 enable", 32'(v), 0);
        rd(2, v); chk("R10 overflow", 32'(v), 0);
        rd(4, v); chk("R10 levels", 32'(v), 0);
        rd(3, v); chk("R2 reset length", 32'(v), 4);
    endtask

    task automatic t_filter();
        logic [NC-1:0] v;
        wr(3, 3);
        chan_in[0] = 1'b1;
        tick(); tick();
        rd(4, v); chk("R1 not yet after 2 ticks", 32'(v[0]), 0);
        tick();
        rd(4, v); chk("R1 level after 3 ticks", 32'(v[0]), 1);
        rd(0, v); chk("R3 cause not before next edge", 32'(v[0]), 0);
        step();
        rd(0, v); chk("R3 change cause", 32'(v[0]), 1);
        chan_in[0] = 1'b0; tick(); tick();
        chan_in[0] = 1'b1; tick();
        chan_in[0] = 1'b0; tick(); tick();
        rd(4, v); chk("R1 restart on matching tick", 32'(v[0]), 1);
        repeat (10) step();
        rd(4, v); chk("R1 idle cycles do not count", 32'(v[0]), 1);
        tick();
        rd(4, v); chk("R1 level after restart", 32'(v[0]), 0);
        step();
        rd(2, v); chk("R8 change overflow", 32'(v[0]), 1);
        wr(0, 1);
        rd(0, v); chk("R6 clear change cause", 32'(v[0]), 0);
        wr(2, 1);
        rd(2, v); chk("R8 overflow cleared", 32'(v[0]), 0);
    endtask

    task automatic t_length();
        logic [NC-1:0] v;
        wr(3, 0);
        rd(3, v); chk("R2 zero stored as one", 32'(v), 1);
        chan_is_in[1] = 1'b0;
        chan_in[1] = 1'b1;
        tick(); step();
        rd(4, v); chk("R2 length one level", 32'(v[1]), 1);
        rd(0, v); chk("R3 output channel silent", 32'(v[1]), 0);
        wr(3, 15);
        rd(3, v); chk("R2 max length", 32'(v), 15);
    endtask

    task automatic t_short();
        logic [NC-1:0] v;
        short_flag[2] = 1'b1; step();
        rd(0, v); chk("R4 short cause", 32'(v[NCH+2]), 1);
        rd(4, v); chk("R4 live short", 32'(v[2*NCH-1:NCH]), 32'h04);
        wr(0, 0);
        rd(0, v); chk("R6 zero write keeps", 32'(v[NCH+2]), 1);
        short_flag[2] = 1'b0; step();
        short_flag[2] = 1'b1; step();
        rd(2, v); chk("R8 short overflow", 32'(v[NCH+2]), 1);
        wr(2, NC'(1) << (NCH + 2));
        short_flag[2] = 1'b0; step();
        reg_addr = 0; reg_wdata = NC'(1) << (NCH + 2); reg_wr = 1'b1;
        short_flag[2] = 1'b1;
        step(); reg_wr = 1'b0;
        rd(0, v); chk("R7 event beats clear", 32'(v[NCH+2]), 1);
        rd(2, v); chk("R7 no overflow", 32'(v[NCH+2]), 0);
    endtask

    task automatic t_thermal();
        logic [NC-1:0] v;
        temp_warn = 1'b1; step();
        rd(0, v); chk("R5 warn cause", 32'(v[2*NCH+1:2*NCH]), 32'b01);
        temp_crit = 1'b1; step();
        rd(0, v); chk("R5 crit cause", 32'(v[2*NCH+1:2*NCH]), 32'b11);
    endtask

    task automatic t_irq();
        chk("R9 masked causes keep line high", 32'(irq_n), 1);
        wr(1, NC'(1) << (2 * NCH));
        chk("R9 still high on enable edge", 32'(irq_n), 1);
        step();
        chk("R9 low after enable", 32'(irq_n), 0);
        wr(0, NC'(1) << (2 * NCH));
        chk("R9 low in clear cycle", 32'(irq_n), 0);
        step();
        chk("R9 released after clear", 32'(irq_n), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_filter();
        t_length();
        t_short();
        t_thermal();
        t_irq();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule